// File: doc/BRIEF.md
# Byte-Level Two-Wire Bus Master

This block is a byte-oriented master for a two-wire serial bus (clock line plus data line, both open-drain). Software drives it through three write selects: a control byte, a data byte and an interrupt/override word. In return it sees the control flags, the data byte and an 8-bit status code. Each command runs one bus phase: a start (or repeated start), one transmitted byte with its acknowledge slot, one received byte with an acknowledge or not-acknowledge, or a stop. When a phase other than stop ends, the block raises an event flag and posts a fixed status code. Software then clears the flag to launch the next phase.

Bus timing comes from a single-cycle oscillator tick supplied by an external divider. Every bit takes exactly four ticks. The two line outputs are active-high "drive low" enables. Two override bits can hold either line low, so software can toggle the clock to free a stuck bus. An interrupt output is high while the interrupt is enabled and the status is anything other than idle.

Top module: `twc_master`

## Requirements
- R1: After reset the status is 0xF8 (idle), the event flag (control bit 3) is 0, the interrupt is low and neither line is driven low.
- R2: A control write with bit 6 (enable) and bit 5 (start) set generates a start condition and then sets the event flag. The status is 0x08 if the bus was free and 0x10 if the block already owned it (repeated start).
- R3: The first byte after a start is the address byte, sent most significant bit first. Its bit 0 selects read (1) or write (0). An acknowledged address posts 0x18 for a write and 0x40 for a read. An unacknowledged address posts 0x20 for a write and 0x48 for a read.
- R4: Each data byte that follows a write address is sent on the bus. It posts 0x28 when the target acknowledges it and 0x30 when it does not.
- R5: After a read address, each launched phase receives one byte into the data register. With control bit 2 set the block acknowledges the byte and posts 0x50. With bit 2 clear it sends a not-acknowledge and posts 0x58.
- R6: While the event flag is set, a control write with enable=1 and flag bit=0 clears the flag and starts the next phase. A control write with enable=0 leaves the flag and the status unchanged.
- R7: A control write with enable and bit 4 (stop) set clears the flag and sets the status to 0xF8 in the next cycle, without raising the event flag. It then drives a stop condition and leaves both lines released. If start and stop are written together, the stop takes precedence and no start is made.
- R8: Bit 6 of the interrupt word enables the interrupt, and writing it as 0 disables it. When enabled, the interrupt output is high exactly while the status is not 0xF8.
- R9: Bit 9 of the interrupt word holds the clock line low and bit 8 holds the data line low, taking effect on the outputs two cycles after the write. Toggling bit 9 nine times gives nine clock pulses on the bus. The override bits do not change the status.
- R10: Bus phases advance only on oscillator ticks (four per bit). While the tick is held low, a launched phase makes no progress and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle bus timing tick from the clock divider |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 data, 1 control, 2 interrupt/override |
| wr_data | input | INT_W | Write value (low 8 bits for data and control) |
| ctl_o | output | 8 | Control readback: bit 6 enable, bit 3 event flag, bit 2 acknowledge select |
| data_o | output | DATA_W | Data register (last received byte or byte to send) |
| status_o | output | 8 | Status code |
| irq_o | output | 1 | Interrupt request |
| sda_in | input | 1 | Sensed level of the data line |
| scl_low_o | output | 1 | Drive the clock line low |
| sda_low_o | output | 1 | Drive the data line low |

## Verification
The function pair that can meet in one cycle is start and stop: a single control write can request both. The bench provokes this with one write carrying both bits on a free bus. It judges the result from the status (idle right after the write), the absence of any later event flag, and both lines being released once the stop sequence has run. A behavioural target on the bus acknowledges its own address, returns counting bytes and refuses the byte 0xFF. This lets every acknowledge and not-acknowledge status be compared by the scoreboard.

// File: rtl/twc_pkg.sv
package twc_pkg;
  localparam logic [7:0] ST_START    = 8'h08;
  localparam logic [7:0] ST_RESTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK   = 8'h18;
  localparam logic [7:0] ST_AW_NACK  = 8'h20;
  localparam logic [7:0] ST_TX_ACK   = 8'h28;
  localparam logic [7:0] ST_TX_NACK  = 8'h30;
  localparam logic [7:0] ST_AR_ACK   = 8'h40;
  localparam logic [7:0] ST_AR_NACK  = 8'h48;
  localparam logic [7:0] ST_RX_ACK   = 8'h50;
  localparam logic [7:0] ST_RX_NACK  = 8'h58;
  localparam logic [7:0] ST_IDLE     = 8'hF8;

  localparam int CB_ENAB = 6;
  localparam int CB_STA  = 5;
  localparam int CB_STP  = 4;
  localparam int CB_FLAG = 3;
  localparam int CB_AAK  = 2;

  localparam int IB_IE   = 6;
  localparam int IB_SDAF = 8;
  localparam int IB_SCLF = 9;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_CTL  = 2'd1;
  localparam logic [1:0] SEL_INT  = 2'd2;

  typedef enum logic [1:0] {C_START, C_STOP, C_WR, C_RD} bit_op_e;
  typedef enum logic [2:0] {B_IDLE, B_START, B_STOP, B_TX, B_TXACK, B_RX, B_RXACK} byte_st_e;
endpackage

// File: rtl/twc_bit_engine.sv
module twc_bit_engine
  import twc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tick,
  input  logic    cmd_valid,
  input  bit_op_e cmd_op,
  input  logic    cmd_bit,
  input  logic    sda_in,
  output logic    busy,
  output logic    done,
  output logic    rx_bit,
  output logic    scl_low,
  output logic    sda_low
);
  localparam int PH_W = 2;
  localparam logic [PH_W-1:0] PH_LAST = '1;

  logic [PH_W-1:0] phase;
  bit_op_e         cur_op;
  logic            cur_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      phase   <= '0;
      cur_op  <= C_RD;
      cur_bit <= 1'b1;
      rx_bit  <= 1'b1;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cmd_valid && !busy) begin
        busy    <= 1'b1;
        phase   <= '0;
        cur_op  <= cmd_op;
        cur_bit <= cmd_bit;
      end else if (busy && tick) begin
        phase <= phase + 1'b1;
        unique case (cur_op)
          C_START: begin
            case (phase)
              2'd0: sda_low <= 1'b0;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b1;
              default: scl_low <= 1'b1;
            endcase
          end
          C_STOP: begin
            case (phase)
              2'd0: scl_low <= 1'b1;
              2'd1: sda_low <= 1'b1;
              2'd2: scl_low <= 1'b0;
              default: sda_low <= 1'b0;
            endcase
          end
          default: begin
            case (phase)
              2'd0: begin
                scl_low <= 1'b1;
                sda_low <= (cur_op == C_WR) ? !cur_bit : 1'b0;
              end
              2'd1: scl_low <= 1'b0;
              2'd2: rx_bit  <= sda_in;
              default: scl_low <= 1'b1;
            endcase
          end
        endcase
        if (phase == PH_LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R10
  tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> ($stable(phase) && $stable(scl_low) && $stable(sda_low)));
endmodule

// File: rtl/twc_byte_ctrl.sv
module twc_byte_ctrl
  import twc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              ctl_enab,
  input  logic              ctl_sta,
  input  logic              ctl_stp,
  input  logic              ctl_flag,
  input  logic              ctl_aak,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic              eng_rx_bit,
  output logic              cmd_valid,
  output bit_op_e           cmd_op,
  output logic              cmd_bit,
  output logic [7:0]        status_o,
  output logic              flag_o,
  output logic              enab_o,
  output logic              aak_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  byte_st_e          state;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              kick;
  logic              owned;
  logic              addr_phase;
  logic              rx_mode;
  logic              rw_bit;

  assign cmd_valid = kick;

  always_comb begin
    unique case (state)
      B_START: cmd_op = C_START;
      B_STOP:  cmd_op = C_STOP;
      B_TX:    cmd_op = C_WR;
      B_RXACK: cmd_op = C_WR;
      default: cmd_op = C_RD;
    endcase
    cmd_bit = (state == B_TX) ? shreg[DATA_W-1] : !aak_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= B_IDLE;
      shreg      <= '0;
      bitcnt     <= '0;
      kick       <= 1'b0;
      owned      <= 1'b0;
      addr_phase <= 1'b0;
      rx_mode    <= 1'b0;
      rw_bit     <= 1'b0;
      status_o   <= ST_IDLE;
      flag_o     <= 1'b0;
      enab_o     <= 1'b0;
      aak_o      <= 1'b0;
      data_o     <= '0;
    end else begin
      kick <= 1'b0;
      if (dat_we) data_o <= dat_wdata;
      unique case (state)
        B_IDLE: begin
          if (ctl_we) begin
            enab_o <= ctl_enab;
            aak_o  <= ctl_aak;
            if (ctl_enab && ctl_stp) begin
              state    <= B_STOP;
              kick     <= 1'b1;
              status_o <= ST_IDLE;
              flag_o   <= 1'b0;
              owned    <= 1'b0;
            end else if (ctl_enab && ctl_sta) begin
              state  <= B_START;
              kick   <= 1'b1;
              flag_o <= 1'b0;
            end else if (ctl_enab && flag_o && !ctl_flag) begin
              flag_o <= 1'b0;
              bitcnt <= '0;
              kick   <= 1'b1;
              if (rx_mode) begin
                state <= B_RX;
              end else begin
                state  <= B_TX;
                shreg  <= data_o;
                rw_bit <= data_o[0];
              end
            end
          end
        end
        B_START: if (eng_done) begin
          status_o   <= owned ? ST_RESTART : ST_START;
          owned      <= 1'b1;
          addr_phase <= 1'b1;
          rx_mode    <= 1'b0;
          flag_o     <= 1'b1;
          state      <= B_IDLE;
        end
        B_STOP: if (eng_done) state <= B_IDLE;
        B_TX: if (eng_done) begin
          shreg  <= shreg << 1;
          bitcnt <= bitcnt + 1'b1;
          kick   <= 1'b1;
          if (bitcnt == LAST_BIT) state <= B_TXACK;
        end
        B_TXACK: if (eng_done) begin
          flag_o <= 1'b1;
          state  <= B_IDLE;
          if (addr_phase) begin
            addr_phase <= 1'b0;
            if (rw_bit) begin
              status_o <= eng_rx_bit ? ST_AR_NACK : ST_AR_ACK;
              rx_mode  <= !eng_rx_bit;
            end else begin
              status_o <= eng_rx_bit ? ST_AW_NACK : ST_AW_ACK;
            end
          end else begin
            status_o <= eng_rx_bit ? ST_TX_NACK : ST_TX_ACK;
          end
        end
        B_RX: if (eng_done) begin
          shreg  <= {shreg[DATA_W-2:0], eng_rx_bit};
          bitcnt <= bitcnt + 1'b1;
          kick   <= 1'b1;
          if (bitcnt == LAST_BIT) state <= B_RXACK;
        end
        B_RXACK: if (eng_done) begin
          data_o   <= shreg;
          status_o <= aak_o ? ST_RX_ACK : ST_RX_NACK;
          flag_o   <= 1'b1;
          state    <= B_IDLE;
        end
        default: state <= B_IDLE;
      endcase
    end
  end

  // R2
  flag_status_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> (status_o != ST_IDLE));
  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_enab && ctl_stp && state == B_IDLE) |=> (status_o == ST_IDLE && !flag_o));
  // R6
  no_enab_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !ctl_enab && flag_o) |=> (flag_o && $stable(status_o)));
  // R10
  kick_idle_chk: assert property (@(posedge clk) disable iff (rst)
    kick |-> !eng_busy);
endmodule

// File: rtl/twc_master.sv
module twc_master
  import twc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int INT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [INT_W-1:0]  wr_data,
  output logic [7:0]        ctl_o,
  output logic [DATA_W-1:0] data_o,
  output logic [7:0]        status_o,
  output logic              irq_o,
  input  logic              sda_in,
  output logic              scl_low_o,
  output logic              sda_low_o
);
  logic    ie, scl_force, sda_force;
  logic    ctl_we, dat_we;
  logic    eng_busy, eng_done, eng_rx_bit, eng_scl_low, eng_sda_low;
  logic    cmd_valid, cmd_bit;
  bit_op_e cmd_op;
  logic    flag, enab, aak;

  assign ctl_we = wr_en && (wr_sel == SEL_CTL);
  assign dat_we = wr_en && (wr_sel == SEL_DATA);
  assign ctl_o  = {1'b0, enab, 2'b00, flag, aak, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      ie        <= 1'b0;
      scl_force <= 1'b0;
      sda_force <= 1'b0;
      irq_o     <= 1'b0;
      scl_low_o <= 1'b0;
      sda_low_o <= 1'b0;
    end else begin
      if (wr_en && wr_sel == SEL_INT) begin
        ie        <= wr_data[IB_IE];
        scl_force <= wr_data[IB_SCLF];
        sda_force <= wr_data[IB_SDAF];
      end
      irq_o     <= ie && (status_o != ST_IDLE);
      scl_low_o <= eng_scl_low || scl_force;
      sda_low_o <= eng_sda_low || sda_force;
    end
  end

  twc_byte_ctrl #(.DATA_W(DATA_W)) u_byte (
    .clk(clk), .rst(rst),
    .ctl_we(ctl_we),
    .ctl_enab(wr_data[CB_ENAB]), .ctl_sta(wr_data[CB_STA]), .ctl_stp(wr_data[CB_STP]),
    .ctl_flag(wr_data[CB_FLAG]), .ctl_aak(wr_data[CB_AAK]),
    .dat_we(dat_we), .dat_wdata(wr_data[DATA_W-1:0]),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_rx_bit(eng_rx_bit),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit),
    .status_o(status_o), .flag_o(flag), .enab_o(enab), .aak_o(aak), .data_o(data_o)
  );

  twc_bit_engine u_bit (
    .clk(clk), .rst(rst), .tick(osc_tick),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit), .sda_in(sda_in),
    .busy(eng_busy), .done(eng_done), .rx_bit(eng_rx_bit),
    .scl_low(eng_scl_low), .sda_low(eng_sda_low)
  );

  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (status_o == ST_IDLE && $past(status_o == ST_IDLE)) |-> !irq_o);
  // R9
  scl_force_chk: assert property (@(posedge clk) disable iff (rst)
    scl_force |=> scl_low_o);
  // R9
  sda_force_chk: assert property (@(posedge clk) disable iff (rst)
    sda_force |=> sda_low_o);
endmodule

// File: tb/twc_master_test.sv
module twc_master_test;
  localparam int DATA_W = 8;
  localparam int INT_W  = 10;
  localparam logic [6:0] SLV = 7'h2C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [INT_W-1:0] wr_data = '0;
  logic [7:0] ctl_o, status_o;
  logic [DATA_W-1:0] data_o;
  logic irq_o, scl_low_o, sda_low_o;
  logic slv_low = 1'b0;
  logic scl_line, sda_line;

  assign scl_line = !scl_low_o;
  assign sda_line = !(sda_low_o || slv_low);

  always #10 clk = ~clk;

  twc_master #(.DATA_W(DATA_W), .INT_W(INT_W)) uut (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ctl_o(ctl_o), .data_o(data_o), .status_o(status_o),
    .irq_o(irq_o), .sda_in(sda_line), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o)
  );

  int checks = 0;
  int fails = 0;
  bit done_flag = 0;
  logic tick_en = 1'b1;
  int tick_cnt = 0;

  always @(negedge clk) begin
    tick_cnt <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
    osc_tick <= tick_en && (tick_cnt == 3);
  end

  // behavioural target
  logic p_scl = 1'b1, p_sda = 1'b1;
  int s_bits = 0;
  bit s_first = 0, s_match = 0, s_rw = 0, s_send = 0, s_active = 0;
  logic [7:0] s_rx = '0, s_tx = '0, s_last_wr = '0, s_txn = '0;
  int scl_falls = 0;

  always @(negedge clk) begin
    p_scl <= scl_line;
    p_sda <= sda_line;
    if (p_scl && !scl_line) scl_falls <= scl_falls + 1;
    if (scl_line && p_scl && p_sda && !sda_line) begin
      s_active <= 1; s_first <= 1; s_bits <= 0; s_send <= 0; slv_low <= 1'b0;
    end else if (scl_line && p_scl && !p_sda && sda_line) begin
      s_active <= 0; s_send <= 0; slv_low <= 1'b0;
    end else if (s_active && !p_scl && scl_line) begin
      if (s_bits < 8) s_rx <= {s_rx[6:0], sda_line};
      else if (s_send && sda_line) s_send <= 0;
      s_bits <= s_bits + 1;
    end else if (s_active && p_scl && !scl_line) begin
      if (s_bits < 8) begin
        if (s_send) slv_low <= !s_tx[7 - s_bits];
      end else if (s_bits == 8) begin
        if (s_send) slv_low <= 1'b0;
        else if (s_first) begin
          s_match <= (s_rx[7:1] == SLV);
          s_rw    <= s_rx[0];
          slv_low <= (s_rx[7:1] == SLV);
        end else if (s_match && !s_rw && s_rx != 8'hFF) begin
          s_last_wr <= s_rx;
          slv_low <= 1'b1;
        end
      end else begin
        s_bits <= 0;
        slv_low <= 1'b0;
        if (s_first) begin
          s_first <= 0;
          if (s_match && s_rw) begin
            s_send <= 1; s_tx <= 8'hA0; s_txn <= 8'hA1; slv_low <= !8'hA0 >> 7;
          end
        end else if (s_send) begin
          s_tx <= s_txn; s_txn <= s_txn + 1'b1; slv_low <= !s_txn[7];
        end
      end
    end
  end

  // scoreboard
  logic [16:0] exp_q[$];
  logic p_flag = 1'b0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    p_flag <= ctl_o[3];
    if (!rst && ctl_o[3] && !p_flag) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected event", {8'h0, status_o}, 16'h0);
      end else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        chk("R2-R5 event status", {8'h0, status_o}, {8'h0, e[7:0]});
        if (e[16]) chk("R5 received byte", {8'h0, data_o}, {8'h0, e[15:8]});
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [INT_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
  endtask

  task automatic wait_flag();
    int n = 0;
    while (!ctl_o[3] && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) chk("R10 event timeout", 16'h0, 16'h1);
    @(negedge clk);
  endtask

  task automatic step(input logic [7:0] ctl, input logic [7:0] st,
                      input bit has_d, input logic [7:0] d);
    exp_q.push_back({has_d, d, st});
    wr(2'd1, {2'b0, ctl});
    wait_flag();
  endtask

  task automatic stop_bus();
    wr(2'd1, 10'h050);
    chk("R7 status idle after stop", {8'h0, status_o}, 16'h00F8);
    chk("R7 flag cleared by stop", {15'h0, ctl_o[3]}, 16'h0);
    repeat (40) @(negedge clk);
    chk("R7 lines released", {14'h0, scl_line, sda_line}, 16'h3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 reset status", {8'h0, status_o}, 16'h00F8);
    chk("R1 reset flag", {15'h0, ctl_o[3]}, 16'h0);
    chk("R1 reset irq", {15'h0, irq_o}, 16'h0);
    chk("R1 reset lines", {14'h0, scl_low_o, sda_low_o}, 16'h0);

    // R2 start on free bus, R8 irq disabled
    step(8'h60, 8'h08, 0, 8'h0);
    chk("R8 irq off when disabled", {15'h0, irq_o}, 16'h0);
    wr(2'd2, 10'h040);
    @(negedge clk);
    chk("R8 irq on non-idle status", {15'h0, irq_o}, 16'h1);
    // R6 ignored write
    wr(2'd1, 10'h000);
    repeat (30) @(negedge clk);
    chk("R6 flag kept on enab=0", {15'h0, ctl_o[3]}, 16'h1);
    chk("R6 status kept on enab=0", {8'h0, status_o}, 16'h0008);
    // R3 write address, R4 data
    wr(2'd0, 10'h058);
    step(8'h40, 8'h18, 0, 8'h0);
    wr(2'd0, 10'h03C);
    step(8'h40, 8'h28, 0, 8'h0);
    chk("R4 target received byte", {8'h0, s_last_wr}, 16'h003C);
    wr(2'd0, 10'h0FF);
    step(8'h40, 8'h30, 0, 8'h0);
    // R2 repeated start, R3 read address, R5 receive
    step(8'h60, 8'h10, 0, 8'h0);
    wr(2'd0, 10'h059);
    step(8'h40, 8'h40, 0, 8'h0);
    step(8'h44, 8'h50, 1, 8'hA0);
    step(8'h40, 8'h58, 1, 8'hA1);
    stop_bus();
    @(negedge clk);
    chk("R8 irq low at idle", {15'h0, irq_o}, 16'h0);

    // R3 address not acknowledged
    step(8'h60, 8'h08, 0, 8'h0);
    wr(2'd0, 10'h022);
    step(8'h40, 8'h20, 0, 8'h0);
    stop_bus();
    step(8'h60, 8'h08, 0, 8'h0);
    wr(2'd0, 10'h023);
    step(8'h40, 8'h48, 0, 8'h0);
    stop_bus();

    // R10 no progress without ticks
    step(8'h60, 8'h08, 0, 8'h0);
    wr(2'd0, 10'h058);
    exp_q.push_back({1'b0, 8'h0, 8'h18});
    tick_en = 1'b0;
    wr(2'd1, 10'h040);
    repeat (300) @(negedge clk);
    chk("R10 no event while tick held", {15'h0, ctl_o[3]}, 16'h0);
    tick_en = 1'b1;
    wait_flag();
    stop_bus();

    // R7 start and stop together
    wr(2'd1, 10'h070);
    chk("R7 stop wins status", {8'h0, status_o}, 16'h00F8);
    repeat (80) @(negedge clk);
    chk("R7 no start event", {15'h0, ctl_o[3]}, 16'h0);
    chk("R7 bus free after combined", {14'h0, scl_line, sda_line}, 16'h3);

    // R9 overrides
    wr(2'd2, 10'h200);
    @(negedge clk);
    chk("R9 clock forced", {14'h0, scl_low_o, sda_low_o}, 16'h2);
    chk("R9 status untouched", {8'h0, status_o}, 16'h00F8);
    wr(2'd2, 10'h100);
    @(negedge clk);
    chk("R9 data forced", {14'h0, scl_low_o, sda_low_o}, 16'h1);
    wr(2'd2, 10'h000);
    @(negedge clk);
    begin
      int f0;
      f0 = scl_falls;
      for (int i = 0; i < 9; i++) begin
        wr(2'd2, 10'h000); repeat (3) @(negedge clk);
        wr(2'd2, 10'h200); repeat (3) @(negedge clk);
      end
      wr(2'd2, 10'h300); repeat (3) @(negedge clk);
      wr(2'd2, 10'h100); repeat (3) @(negedge clk);
      wr(2'd2, 10'h000); repeat (3) @(negedge clk);
      chk("R9 nine clock pulses", 16'(scl_falls - f0), 16'd9);
    end
    chk("R9 lines released after unblock", {14'h0, scl_line, sda_line}, 16'h3);
    chk("R9 status after unblock", {8'h0, status_o}, 16'h00F8);
    chk("R2-R5 all events seen", 16'(exp_q.size()), 16'h0);

    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule